// File: doc/BRIEF.md
# Split-Chain LCD Segment Driver Core

This block is the digital core of a 40-segment liquid-crystal segment driver. Serial segment data enters a shift register that is built as two 20-stage sections. Each section has its own serial input and its own serial output tap. Used alone, the two sections load two independent 20-bit words. When the first section's tap is wired back to the second section's input, the two sections form one 40-stage chain. The last tap can then feed the first input of a further driver, so that several drivers cascade into a wider display.

A level-sensitive latch sits between the register and the segment outputs. While the load input is high, the latch follows the register. While load is low, the latch keeps its last contents. Each segment drives a 2-bit code that selects one of four analog drive levels. The code depends on that segment's latched bit and on an AC polarity input, which the display controller toggles to keep DC off the panel.

The shift clock, both serial inputs, load and polarity are asynchronous pins. All five pass through one shared synchronizer into the system clock domain. A shift happens in the system cycle in which a high-to-low transition of the synchronized shift clock is seen. The serial pins are plain levels with no handshake. The controller paces the data, and no back-pressure exists: every detected falling edge consumes one bit on each input.

Top module: `lcdseg_driver`

## Requirements
- R1: The register advances by one position only when the synchronized shift clock is seen to go from 1 to 0. A rise of the shift clock, or a steady level, leaves the register and both serial taps unchanged. Each input pin passes through SYNC_STAGES flops before it is used.
- R2: On a shift, the first section takes din_a_i into segment position 1, and the second section takes din_b_i into position 21. Each other position takes the value of the position before it within its own section.
- R3: dout_a_o carries position 20 and dout_b_o carries position 40. Both change only on a shift. In the joined chain, a bit entered on din_a_i appears on dout_a_o after 20 shifts and on dout_b_o after 40 shifts.
- R4: While synchronized load is 1, the latch copies the register every cycle. While it is 0, the latch holds, and shifts do not change seg_lvl_o.
- R5: Segment n (1 to 40) occupies seg_lvl_o bits [2n-1:2n-2] and shows latched position n. In the joined chain, the first bit shifted in ends at segment 40 after 40 shifts.
- R6: The segment code is set by the latched bit and the polarity as follows:
  - code 00 (top supply) for latched 1 with polarity 0;
  - code 01 (upper-middle bias) for latched 0 with polarity 0;
  - code 10 (lower-middle bias) for latched 0 with polarity 1;
  - code 11 (lowest bias) for latched 1 with polarity 1.
- R7: The active-low asynchronous reset rst_n clears the register, the latch and the synchronizer. After reset, both taps are 0 and every segment shows the code for latched 0 at the current polarity (01 at polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Shift clock; acts on its falling edge |
| din_a_i | input | 1 | Serial input of the first section (position 1) |
| din_b_i | input | 1 | Serial input of the second section (position 21) |
| load_i | input | 1 | Latch transparent when 1, holding when 0 |
| pol_i | input | 1 | AC drive polarity |
| dout_a_o | output | 1 | Serial tap of position 20 |
| dout_b_o | output | 1 | Serial tap of position 40, for cascading |
| seg_lvl_o | output | 80 | Two-bit level code per segment, segment 1 in the low bits |

## Verification
The case that is hardest to reach from the pins is the joined chain. There, din_b_i is the design's own dout_a_o, fed back through the synchronizer. The feedback must arrive after the shift that uses the old value and before the next one. The bench keeps a switchable wire from dout_a_o to din_b_i. It clears the whole chain, then walks a single 1 through it, with several system cycles per shift-clock phase. It checks the taps at shifts 19, 20, 21, 39 and 40. A reference model, which steps through the synchronizer delay on every clock, watches every cycle of the walk.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  // Two-bit drive level selector presented on each segment.
  typedef enum logic [1:0] {
    LVL_TOP   = 2'b00,
    LVL_UPMID = 2'b01,
    LVL_LOMID = 2'b10,
    LVL_BOT   = 2'b11
  } lvl_e;

  // Latched bit and polarity pick one of four levels.
  function automatic lvl_e pick_level(input logic seg_on, input logic pol);
    lvl_e lvl;
    unique case ({seg_on, pol})
      2'b11:   lvl = LVL_BOT;
      2'b10:   lvl = LVL_TOP;
      2'b01:   lvl = LVL_LOMID;
      default: lvl = LVL_UPMID;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/lcdseg_sync.sv
module lcdseg_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lcdseg_shift_half.sv
module lcdseg_shift_half #(
  parameter int HALF_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              ser_i,
  output logic [HALF_W-1:0] bits_o,
  output logic              ser_o
);

  logic [HALF_W-1:0] bits_q;

  // Index 0 is the entry position of this section.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (step_i) bits_q <= {bits_q[HALF_W-2:0], ser_i};
  end

  assign bits_o = bits_q;
  assign ser_o  = bits_q[HALF_W-1];

endmodule

// File: rtl/lcdseg_level_map.sv
module lcdseg_level_map
  import lcdseg_pkg::*;
#(
  parameter int SEG_N = 40
) (
  input  logic [SEG_N-1:0]   lat_i,
  input  logic               pol_i,
  output logic [2*SEG_N-1:0] lvl_o
);

  generate
    for (genvar n = 0; n < SEG_N; n++) begin : g_seg
      lvl_e lvl;
      assign lvl            = pick_level(lat_i[n], pol_i);
      assign lvl_o[2*n +: 2] = lvl;
    end
  endgenerate

endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
  import lcdseg_pkg::*;
#(
  parameter int HALF_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  din_a_i,
  input  logic                  din_b_i,
  input  logic                  load_i,
  input  logic                  pol_i,
  output logic                  dout_a_o,
  output logic                  dout_b_o,
  output logic [4*HALF_W-1:0]   seg_lvl_o
);

  localparam int NUM_HALVES = 2;
  localparam int SEG_N      = NUM_HALVES * HALF_W;
  localparam int SYNC_W     = 5;

  logic [SYNC_W-1:0] sync_in;
  logic [SYNC_W-1:0] sync_out;
  logic              sclk_s, din_a_s, din_b_s, load_s, pol_s;
  logic              sclk_prev_q;
  logic              fall_w;
  logic              ser_in_w  [NUM_HALVES];
  logic              ser_out_w [NUM_HALVES];
  logic [SEG_N-1:0]  shreg_w;
  logic [SEG_N-1:0]  latch_q;

  assign sync_in = {pol_i, load_i, din_b_i, din_a_i, sclk_i};

  lcdseg_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );

  assign {pol_s, load_s, din_b_s, din_a_s, sclk_s} = sync_out;

  // Falling-edge detect on the synchronized shift clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign fall_w = sclk_prev_q & ~sclk_s;

  assign ser_in_w[0] = din_a_s;
  assign ser_in_w[1] = din_b_s;

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      lcdseg_shift_half #(
        .HALF_W (HALF_W)
      ) half_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (fall_w),
        .ser_i  (ser_in_w[h]),
        .bits_o (shreg_w[h*HALF_W +: HALF_W]),
        .ser_o  (ser_out_w[h])
      );
    end
  endgenerate

  assign dout_a_o = ser_out_w[0];
  assign dout_b_o = ser_out_w[1];

  // Level-sensitive latch modelled as a per-cycle enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (load_s) latch_q <= shreg_w;
  end

  lcdseg_level_map #(
    .SEG_N (SEG_N)
  ) map_i (
    .lat_i (latch_q),
    .pol_i (pol_s),
    .lvl_o (seg_lvl_o)
  );

endmodule

// File: rtl/lcdseg_driver_chk.sv
module lcdseg_driver_chk #(
  parameter int HALF_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sclk_s,
  input logic                sclk_prev_q,
  input logic                din_a_s,
  input logic                din_b_s,
  input logic                load_s,
  input logic                pol_s,
  input logic [2*HALF_W-1:0] shreg_w,
  input logic [2*HALF_W-1:0] latch_q,
  input logic                dout_a_o,
  input logic                dout_b_o,
  input logic [4*HALF_W-1:0] seg_lvl_o
);

  localparam int SEG_N = 2 * HALF_W;

  assert_still_without_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_prev_q && !sclk_s) |=> $stable(shreg_w));

  assert_entry_taps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_prev_q && !sclk_s) |=>
      (shreg_w[0] == $past(din_a_s) && shreg_w[HALF_W] == $past(din_b_s)));

  assert_tail_taps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_prev_q && !sclk_s) |=>
      (dout_a_o == $past(shreg_w[HALF_W-2]) && dout_b_o == $past(shreg_w[SEG_N-2])));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> $stable(latch_q));

  assert_latch_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> (latch_q == $past(shreg_w)));

  assert_level_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_lvl_o[1] == pol_s) && (seg_lvl_o[0] == (latch_q[0] == pol_s)) &&
    (seg_lvl_o[2*SEG_N-1] == pol_s) &&
    (seg_lvl_o[2*SEG_N-2] == (latch_q[SEG_N-1] == pol_s)));

endmodule

bind lcdseg_driver lcdseg_driver_chk #(.HALF_W(HALF_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_s      (sclk_s),
  .sclk_prev_q (sclk_prev_q),
  .din_a_s     (din_a_s),
  .din_b_s     (din_b_s),
  .load_s      (load_s),
  .pol_s       (pol_s),
  .shreg_w     (shreg_w),
  .latch_q     (latch_q),
  .dout_a_o    (dout_a_o),
  .dout_b_o    (dout_b_o),
  .seg_lvl_o   (seg_lvl_o)
);

// File: tb/lcdseg_driver_tb.sv
`timescale 1ns/1ps
module lcdseg_driver_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, din_a = 1'b0, din_b_drv = 1'b0, load = 1'b0, pol = 1'b0;
  logic joined = 1'b0;
  logic din_b_w;
  logic dout_a, dout_b;
  logic [79:0] seg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign din_b_w = joined ? dout_a : din_b_drv;

  lcdseg_driver dut_i (
    .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .din_a_i (din_a),
    .din_b_i (din_b_w), .load_i (load), .pol_i (pol),
    .dout_a_o (dout_a), .dout_b_o (dout_b), .seg_lvl_o (seg)
  );

  // ---------------- behavioural reference ----------------
  logic [39:0] m_sr, m_lat;
  logic [4:0]  hist [$];   // {pol, load, b, a, sclk}, newest at front

  function automatic logic [1:0] code_of(input logic on, input logic p);
    if (on && p)  return 2'b11;
    if (on)       return 2'b00;
    if (p)        return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [79:0] exp_seg();
    logic [79:0] v;
    logic p;
    p = (hist.size() > 1) ? hist[1][4] : 1'b0;
    for (int n = 0; n < 40; n++) v[2*n +: 2] = code_of(m_lat[n], p);
    return v;
  endfunction

  always @(posedge clk) begin
    logic [4:0] cur, s2, s3;
    logic [39:0] old_sr;
    if (!rst_n) begin
      m_sr = '0; m_lat = '0; hist = {5'b0, 5'b0, 5'b0};
    end else begin
      cur = {pol, load, (joined ? m_sr[19] : din_b_drv), din_a, sclk};
      s2 = hist[1]; s3 = hist[2];
      old_sr = m_sr;
      if (s2[3]) m_lat = old_sr;
      if (s3[0] && !s2[0]) begin
        for (int i = 39; i > 0; i--) if (i != 20) m_sr[i] = old_sr[i-1];
        m_sr[0]  = s2[1];
        m_sr[20] = s2[2];
      end
      hist.push_front(cur);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done && hist.size() == 3) begin
      check(seg == exp_seg(), "R5", seg, exp_seg());
      check(dout_a == m_sr[19], "R3", 80'(dout_a), 80'(m_sr[19]));
      check(dout_b == m_sr[39], "R3", 80'(dout_b), 80'(m_sr[39]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic a, input logic b);
    @(negedge clk);
    din_a = a; din_b_drv = b; sclk = 1'b1;
    wait_cyc(6);
    sclk = 1'b0;
    wait_cyc(6);
  endtask

  function automatic logic [79:0] fill(input logic [1:0] c);
    logic [79:0] v;
    for (int n = 0; n < 40; n++) v[2*n +: 2] = c;
    return v;
  endfunction

  initial begin : watchdog
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [79:0] snap;
    logic        sa, sb;
    wait_cyc(3);
    // R7: reset state
    check(seg == fill(2'b01), "R7", seg, fill(2'b01));
    check(dout_a == 1'b0 && dout_b == 1'b0, "R7", {dout_a, dout_b}, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);
    pol = 1'b1; wait_cyc(4);
    check(seg == fill(2'b10), "R7", seg, fill(2'b10));
    pol = 1'b0;

    // R2/R6: split mode, distinct words in each section
    load = 1'b1;
    for (int i = 0; i < 20; i++) shift_bit(1'b1, 1'b0);
    wait_cyc(4);
    check(seg[39:0] == fill(2'b00)[39:0] && seg[79:40] == fill(2'b01)[79:40], "R2", seg,
          {fill(2'b01)[79:40], fill(2'b00)[39:0]});
    pol = 1'b1; wait_cyc(4);
    check(seg[39:0] == fill(2'b11)[39:0] && seg[79:40] == fill(2'b10)[79:40], "R6", seg,
          {fill(2'b10)[79:40], fill(2'b11)[39:0]});

    // R6: all four combinations across whole panel
    for (int i = 0; i < 20; i++) shift_bit(1'b1, 1'b1);
    wait_cyc(4);
    check(seg == fill(2'b11), "R6", seg, fill(2'b11));
    pol = 1'b0; wait_cyc(4);
    check(seg == fill(2'b00), "R6", seg, fill(2'b00));
    for (int i = 0; i < 20; i++) shift_bit(1'b0, 1'b0);
    wait_cyc(4);
    check(seg == fill(2'b01), "R6", seg, fill(2'b01));
    pol = 1'b1; wait_cyc(4);
    check(seg == fill(2'b10), "R6", seg, fill(2'b10));
    pol = 1'b0; wait_cyc(4);

    // R4: load low holds outputs while shifting
    load = 1'b0; wait_cyc(4);
    snap = seg;
    for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b1);
    check(seg == snap, "R4", seg, snap);
    load = 1'b1; wait_cyc(5);
    check(seg[9:0] == fill(2'b00)[9:0], "R4", seg, fill(2'b00));

    // R1: a rising shift clock alone changes nothing
    sa = dout_a; sb = dout_b; snap = seg;
    @(negedge clk) sclk = 1'b1;
    wait_cyc(8);
    check(dout_a == sa && dout_b == sb && seg == snap, "R1", {dout_a, dout_b, seg}, {sa, sb, snap});
    @(negedge clk) sclk = 1'b0;
    wait_cyc(6);

    // R3/R5: joined chain, walk a single one through 40 positions
    joined = 1'b1; load = 1'b0;
    for (int i = 0; i < 40; i++) shift_bit(1'b0, 1'b0);
    check(dout_a == 1'b0 && dout_b == 1'b0, "R3", {dout_a, dout_b}, 0);
    for (int n = 1; n <= 40; n++) begin
      shift_bit(n == 1, 1'b0);
      if (n == 19 || n == 20 || n == 21)
        check(dout_a == (n == 20), "R3", 80'(dout_a), 80'(n == 20));
      if (n == 39 || n == 40)
        check(dout_b == (n == 40), "R3", 80'(dout_b), 80'(n == 40));
    end
    load = 1'b1; wait_cyc(5);
    check(seg[79:78] == 2'b00 && seg[77:0] == fill(2'b01)[77:0], "R5", seg,
          {2'b00, fill(2'b01)[77:0]});

    // R7: asynchronous reset mid-operation
    @(negedge clk) rst_n = 1'b0;
    #2;
    check(seg == fill(2'b01) && dout_a == 1'b0 && dout_b == 1'b0, "R7", seg, fill(2'b01));
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule